// File: doc/BRIEF.md
# Configurable Output Macrocell for a Programmable Logic Array

This block is a single output cell of a sum-of-products logic device. It takes the OR-array sum that belongs to it, a per-cell output-enable product term, the two global terms for synchronous set and asynchronous clear, a clock and a three-bit configuration code. It holds one D flip-flop. It chooses whether the pin shows the flip-flop or the raw sum, applies a selectable polarity, and routes one of two feedback sources back into the array.

The pin is modelled as a data line plus a drive enable. The external value seen on the pin when the cell is not driving arrives on a separate input. A start-up reset input holds the flip-flop low. That input is asserted asynchronously and released through a short synchronizer, so the first capture after start-up lands a fixed number of clock edges later.

Top module: `pld_macrocell`

## Requirements
- R1: While `rst_n` is low the flip-flop reads 0. A registered cell then shows 1 on `pin_out_o` when `cfg_i[0]`=0 and 0 when `cfg_i[0]`=1, and register feedback reads 0.
- R2: With the cell out of reset, clear low and set low, the flip-flop takes the value of `sum_i` at each rising clock edge.
- R3: When `preset_term_i` is high at a rising edge and clear is low, the flip-flop becomes 1 at that edge, whatever `sum_i` is.
- R4: When `clear_term_i` goes high, the flip-flop drops to 0 at once, with no clock edge needed.
- R5: When clear and set are both high, the flip-flop stays 0 across clock edges.
- R6: When `cfg_i[1]`=1 the output is combinational: `pin_out_o` follows `sum_i` in the same cycle, and `cfg_i[2]` has no effect.
- R7: `cfg_i[0]` selects polarity: 1 passes the selected value through unchanged, 0 inverts it. This holds for both registered and combinational output.
- R8: `pin_oe_o` is high exactly when `oe_term_i` is high; otherwise the pin is high-impedance.
- R9: Feedback `fb_o` is the flip-flop's true output when `cfg_i[2:1]`=00, and the resolved pin value for every other code.
- R10: The resolved pin value is `pin_out_o` while `pin_oe_o` is high, and `pin_in_i` while it is low.
- R11: When clear falls between clock edges, the flip-flop stays 0 until the next rising edge, which then loads it normally.
- R12: After `rst_n` rises, the flip-flop first loads on rising edge number SYNC_STAGES+1. That is the third edge with the default of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, rising edge active |
| rst_n | input | 1 | Start-up reset, active low, asserted asynchronously |
| sum_i | input | 1 | OR-array sum for this cell |
| oe_term_i | input | 1 | Output-enable product term |
| preset_term_i | input | 1 | Global synchronous set term |
| clear_term_i | input | 1 | Global asynchronous clear term |
| cfg_i | input | 3 | Configuration code: [0] polarity, [1] combinational, [2] pin feedback in registered mode |
| pin_in_i | input | 1 | Value present on the pin from outside |
| pin_out_o | output | 1 | Value driven onto the pin |
| pin_oe_o | output | 1 | Pin drive enable |
| fb_o | output | 1 | Feedback returned to the array |

## Verification
A flip-flop holding the wrong value shows on `pin_out_o` in the first cycle after the faulty edge in any registered code, inverted under active-low polarity. It also shows on `fb_o` in the same cycle under code 00x. A wrong decode of the configuration code shows combinationally: the pin shows the sum where the flip-flop was expected, or the feedback follows `pin_in_i` where it should follow the register. Clear and reset faults are exposed within one cycle, because the output is checked both between edges and just after them.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int CFG_W = 3;

  typedef struct packed {
    logic comb_out;   // 1: pin shows the raw sum
    logic fb_pin;     // 1: feedback from the resolved pin
    logic act_high;   // 1: no inversion on the pin
  } mc_mode_t;
endpackage

// File: rtl/mc_mode_decode.sv
module mc_mode_decode
  import mc_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  output mc_mode_t         mode_o
);
  always_comb begin
    mode_o.act_high = cfg_i[0];
    mode_o.comb_out = cfg_i[1];
    // combinational cells always feed back from the pin; C2 only matters when registered
    mode_o.fb_pin   = cfg_i[1] | cfg_i[2];
  end
endmodule

// File: rtl/mc_reset_sync.sv
module mc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
      assign rst_ok_o = sync_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end
      assign rst_ok_o = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mc_state_flop.sv
module mc_state_flop (
  input  logic clk,
  input  logic rst_ok_i,
  input  logic clr_i,
  input  logic set_i,
  input  logic d_i,
  output logic q_o
);
  logic clr_n;
  logic q_nxt;

  assign clr_n = rst_ok_i & ~clr_i;

  always_comb begin
    q_nxt = d_i;
    if (set_i) q_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q_o <= 1'b0;
    else        q_o <= q_nxt;
  end
endmodule

// File: rtl/mc_out_path.sv
module mc_out_path
  import mc_pkg::*;
(
  input  mc_mode_t mode_i,
  input  logic     sum_i,
  input  logic     q_i,
  input  logic     oe_i,
  input  logic     pin_in_i,
  output logic     pin_out_o,
  output logic     pin_oe_o,
  output logic     fb_o
);
  logic sel_val;
  logic pin_res;

  always_comb begin
    sel_val   = mode_i.comb_out ? sum_i : q_i;
    pin_out_o = mode_i.act_high ? sel_val : ~sel_val;
    pin_oe_o  = oe_i;
    pin_res   = oe_i ? pin_out_o : pin_in_i;
    fb_o      = mode_i.fb_pin ? pin_res : q_i;
  end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import mc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sum_i,
  input  logic             oe_term_i,
  input  logic             preset_term_i,
  input  logic             clear_term_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             pin_in_i,
  output logic             pin_out_o,
  output logic             pin_oe_o,
  output logic             fb_o
);
  mc_mode_t mode_w;
  logic     rst_sync_n;
  logic     q_w;

  mc_mode_decode u_dec (
    .cfg_i  (cfg_i),
    .mode_o (mode_w)
  );

  mc_reset_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_ok_o (rst_sync_n)
  );

  mc_state_flop u_ff (
    .clk      (clk),
    .rst_ok_i (rst_sync_n),
    .clr_i    (clear_term_i),
    .set_i    (preset_term_i),
    .d_i      (sum_i),
    .q_o      (q_w)
  );

  mc_out_path u_out (
    .mode_i    (mode_w),
    .sum_i     (sum_i),
    .q_i       (q_w),
    .oe_i      (oe_term_i),
    .pin_in_i  (pin_in_i),
    .pin_out_o (pin_out_o),
    .pin_oe_o  (pin_oe_o),
    .fb_o      (fb_o)
  );
endmodule

// File: rtl/mc_checker.sv
module mc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_ok,
  input logic       q,
  input logic       sum,
  input logic       oe,
  input logic       preset,
  input logic       clear,
  input logic [2:0] cfg,
  input logic       pin_in,
  input logic       pin_out,
  input logic       pin_oe,
  input logic       fb
);
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && !clear && !preset) |=> (clear || q == $past(sum)));

  p_preset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && preset && !clear) |=> (clear || q));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !q);

  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && preset) |=> (!clear || !q));

  p_comb_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[1] |-> (pin_out == (cfg[0] ? sum : !sum)));

  p_reg_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[1] |-> (pin_out == (cfg[0] ? q : !q)));

  p_regfb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[2:1] == 2'b00) |-> (fb == q));

  p_hiz_fb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe && (cfg[2] || cfg[1])) |-> (fb == pin_in));

  p_drive_fb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && (cfg[2] || cfg[1])) |-> (fb == pin_out));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ok |-> !q);
endmodule

bind pld_macrocell mc_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rst_ok  (rst_sync_n),
  .q       (q_w),
  .sum     (sum_i),
  .oe      (oe_term_i),
  .preset  (preset_term_i),
  .clear   (clear_term_i),
  .cfg     (cfg_i),
  .pin_in  (pin_in_i),
  .pin_out (pin_out_o),
  .pin_oe  (pin_oe_o),
  .fb      (fb_o)
);

// File: tb/tb_pld_macrocell.sv
module tb_pld_macrocell;
  logic       clk;
  logic       rst_n;
  logic       sum_i;
  logic       oe_term_i;
  logic       preset_term_i;
  logic       clear_term_i;
  logic [2:0] cfg_i;
  logic       pin_in_i;
  logic       pin_out_o;
  logic       pin_oe_o;
  logic       fb_o;

  int n_chk;
  int n_bad;

  pld_macrocell dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .sum_i         (sum_i),
    .oe_term_i     (oe_term_i),
    .preset_term_i (preset_term_i),
    .clear_term_i  (clear_term_i),
    .cfg_i         (cfg_i),
    .pin_in_i      (pin_in_i),
    .pin_out_o     (pin_out_o),
    .pin_oe_o      (pin_oe_o),
    .fb_o          (fb_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [23:0] tag;
    logic [2:0]  cfg;
    logic        sum;
    logic        pre;
    logic        oe;
    logic        pin;
    logic        exp_out;
    logic        exp_fb;
  } vec_t;

  // applied before a rising edge, checked 5 ns after it; flop value noted at right
  localparam vec_t VECS [14] = '{
    '{"R2 ", 3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // q=1, inverted pin, fb from q
    '{"R7 ", 3'b001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // q=0
    '{"R9 ", 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // q=1, pin ignored
    '{"R10", 3'b101, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // q=0, fb=pin_in
    '{"R10", 3'b101, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // q=1, fb=driven
    '{"R9 ", 3'b100, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // q=1, low polarity
    '{"R6 ", 3'b010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // comb, inverted sum
    '{"R6 ", 3'b011, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // comb, true sum
    '{"R6 ", 3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // C2 ignored, fb=pin_in
    '{"R10", 3'b110, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // comb low, hi-z fb
    '{"R3 ", 3'b001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // set beats sum, q=1
    '{"R2 ", 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // q=0
    '{"R3 ", 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // q=1
    '{"R7 ", 3'b110, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}  // comb low, q=1
  };

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b1;
    sum_i = 1'b1;
    oe_term_i = 1'b1;
    preset_term_i = 1'b0;
    clear_term_i = 1'b0;
    cfg_i = 3'b000;
    pin_in_i = 1'b0;
    #1 rst_n = 1'b0;

    // R1: held in reset across edges
    repeat (2) @(posedge clk);
    #5;
    chk("R1", "pin_out low-pol", pin_out_o, 1'b1);
    chk("R1", "fb", fb_o, 1'b0);
    chk("R8", "pin_oe", pin_oe_o, 1'b1);
    cfg_i = 3'b001;
    #1 chk("R1", "pin_out high-pol", pin_out_o, 1'b0);

    // R12: first load on edge SYNC_STAGES+1
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #5 chk("R12", "edge1", pin_out_o, 1'b0);
    @(posedge clk); #5 chk("R12", "edge2", pin_out_o, 1'b0);
    @(posedge clk); #5 chk("R12", "edge3", pin_out_o, 1'b1);

    // table walk
    foreach (VECS[i]) begin
      @(negedge clk);
      cfg_i = VECS[i].cfg;
      sum_i = VECS[i].sum;
      preset_term_i = VECS[i].pre;
      oe_term_i = VECS[i].oe;
      pin_in_i = VECS[i].pin;
      @(posedge clk);
      #5;
      chk(string'(VECS[i].tag), "pin_out", pin_out_o, VECS[i].exp_out);
      chk(string'(VECS[i].tag), "fb", fb_o, VECS[i].exp_fb);
      chk("R8", "pin_oe", pin_oe_o, VECS[i].oe);
    end

    // R4 / R5 / R11
    @(negedge clk);
    cfg_i = 3'b001; sum_i = 1'b1; preset_term_i = 1'b0; oe_term_i = 1'b1;
    @(posedge clk); #5 chk("R2", "q set before clear", pin_out_o, 1'b1);
    #2 clear_term_i = 1'b1;
    #1 chk("R4", "async clear", pin_out_o, 1'b0);
    chk("R9", "fb after clear", fb_o, 1'b0);
    preset_term_i = 1'b1;
    @(posedge clk); #5 chk("R5", "clear over set", pin_out_o, 1'b0);
    #3 clear_term_i = 1'b0; preset_term_i = 1'b0;
    #1 chk("R11", "held until edge", pin_out_o, 1'b0);
    @(posedge clk); #5 chk("R11", "load after release", pin_out_o, 1'b1);
    @(negedge clk) sum_i = 1'b0;
    @(posedge clk); #5 chk("R2", "capture zero", pin_out_o, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule